// File: doc/BRIEF.md
# Serial PHY Management Master

This block is a master for the two-wire PHY management bus. It reads and writes 16-bit registers in an external PHY. It produces the management clock itself from the system clock. The clock is split by a divider parameter, so every management clock level lasts `HALF_CYC` system cycles. The data line appears as three separate signals: a driven value, an output enable and a sampled input. The pad that joins them lives outside the block.

A host pulses `start` with a direction, a PHY address, a register address and, for writes, the write data. An optional run of 32 ones can go ahead of the frame. A read sends a 15-bit command, releases the line and clocks a 19-bit window. The PHY must pull the second turnaround slot low. If it does not, the result becomes all ones and an error is raised. A write sends a 32-bit frame and then clocks two idle cycles with the line released. `busy` covers the whole exchange, and `done` marks its end.

Top module: `phy_mgmt_master`

## Requirements
- R1: Each high and each low level of `mdc` during a transaction lasts exactly `HALF_CYC` system clocks. The default of 50 at a 250 MHz system clock gives 200 ns, which keeps the rate at or below 2.5 MHz. A transaction with N clock periods takes N*2*`HALF_CYC` cycles, counted from the edge that samples `start` to the edge that raises `done`.
- R2: With `pre_en`=1, a transaction begins with 32 clock periods that drive a one. With `pre_en`=0, no such bits are sent.
- R3: Driven bits go out MSB first. `mdo` changes only at the edge where `mdc` falls, or at the start of a transaction, and it holds steady while `mdc` is high.
- R4: A read command is 15 bits, in the order 1, 0, 1, 1, 0, `phy_addr`[4:0], `reg_addr`[4:0].
- R5: After the read command, `mdo_oe` is low for exactly 19 `mdc` periods. `mdi` is sampled on the system edge at which `mdc` rises. The first sample is window bit 18.
- R6: Window bit 17 is the second turnaround slot. If it is 1, `rd_data` becomes 16'hFFFF and `err` becomes 1. Otherwise `rd_data` takes window bits 16..1 (bit 16 is the MSB) and `err` becomes 0. A write leaves `err` at 0.
- R7: A write frame is 32 bits, in the order 0, 1, 0, 1, `phy_addr`, `reg_addr`, 1, 0, `wr_data`[15:0].
- R8: After a write frame, `mdo_oe` is low for exactly two more `mdc` periods before `done`.
- R9: `busy` rises on the edge that samples `start`. `done` is high for exactly one cycle, on the edge where the last `mdc` period falls, and `busy` drops on that same edge.
- R10: A `start` pulse while `busy` is high has no effect. The running frame, its length and its result are unchanged, and no second transaction follows.
- R11: After reset, and whenever the block is idle, `mdc`=0, `mdo_oe`=0, `busy`=0 and `done`=0. A reset in the middle of a transaction returns the block to this state.
- R12: `mdo_oe` is high exactly while the preamble, the read command or the write frame is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| rd_sel | input | 1 | 1 = read, 0 = write |
| pre_en | input | 1 | Send 32 preamble ones first |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Result of the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last read failed the turnaround check |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data value driven onto the line |
| mdo_oe | output | 1 | Drive enable for the data line |
| mdi | input | 1 | Sampled state of the data line |

## Verification
Every result appears a fixed number of cycles after the edge that samples `start`. `busy` appears at once. `done`, `rd_data` and `err` appear after exactly the number of clock periods in the frame times 2*`HALF_CYC`. Each `mdo` bit becomes visible at a falling `mdc` edge. The bench drives inputs and samples outputs on the falling system clock. It counts cycles from the start edge and demands that `done` appear on exactly the computed count. A monitor records `mdo` and `mdo_oe` in the first cycle after each `mdc` rise. The modelled PHY steps its response bit in the same cycle, so the next rising edge samples the intended window position.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int ADDR_W        = 5;
  localparam int DATA_W        = 16;
  localparam int PRE_BITS      = 32;
  localparam int RD_CMD_BITS   = 15;
  localparam int WR_FRAME_BITS = 32;
  localparam int RD_WIN_BITS   = 19;
  localparam int TAIL_BITS     = 2;
  localparam int SREG_W        = WR_FRAME_BITS;
  localparam int CNT_W         = $clog2(PRE_BITS);
  // turnaround slot plus data bits kept from the read window
  localparam int KEEP_W        = DATA_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_CMD,
    PH_RWIN,
    PH_TAIL
  } phase_e;

  // Frame left-aligned in the shift register, next bit in the MSB.
  function automatic logic [SREG_W-1:0] build_frame(
      input logic              is_read,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad,
      input logic [DATA_W-1:0] wd);
    logic [SREG_W-1:0] f;
    if (is_read)
      f = {5'b10110, phy, regad, {(SREG_W - RD_CMD_BITS){1'b0}}};
    else
      f = {4'b0101, phy, regad, 2'b10, wd};
    return f;
  endfunction

endpackage

// File: rtl/phy_mgmt_clkgen.sv
module phy_mgmt_clkgen #(
  parameter int HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);

  logic mdc_q;
  logic last_w;

  generate
    if (HALF_CYC <= 1) begin : g_nodiv
      assign last_w = 1'b1;
      always_ff @(posedge clk) begin
        if (rst || !run) mdc_q <= 1'b0;
        else             mdc_q <= ~mdc_q;
      end
    end else begin : g_div
      localparam int CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt_q;
      assign last_w = (cnt_q == CW'(HALF_CYC - 1));
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
          mdc_q <= 1'b0;
        end else if (last_w) begin
          cnt_q <= '0;
          mdc_q <= ~mdc_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign mdc     = mdc_q;
  assign rise_ev = run && !mdc_q && last_w;
  assign fall_ev = run &&  mdc_q && last_w;

endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_sel,
  input  logic              pre_en,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdi,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic              mdo,
  output logic              mdo_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);

  phase_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SREG_W-1:0] sreg_q;
  logic [KEEP_W-1:0] acc_q;
  logic              is_rd_q;
  logic              run_q, busy_q, done_q, mdo_q, oe_q, err_q;
  logic [DATA_W-1:0] rd_q;
  logic [SREG_W-1:0] frame_w;
  logic [CNT_W-1:0]  cmd_len_w;

  assign frame_w   = build_frame(rd_sel, phy_addr, reg_addr, wr_data);
  assign cmd_len_w = rd_sel ? CNT_W'(RD_CMD_BITS - 1) : CNT_W'(WR_FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
      acc_q   <= '0;
      is_rd_q <= 1'b0;
      run_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      // the idle slot at the end of the window is clocked but not kept
      if (rise_ev && st_q == PH_RWIN && cnt_q != '0)
        acc_q <= {acc_q[KEEP_W-2:0], mdi};
      case (st_q)
        PH_IDLE: begin
          if (start) begin
            is_rd_q <= rd_sel;
            busy_q  <= 1'b1;
            run_q   <= 1'b1;
            oe_q    <= 1'b1;
            acc_q   <= '0;
            if (pre_en) begin
              st_q   <= PH_PRE;
              cnt_q  <= CNT_W'(PRE_BITS - 1);
              mdo_q  <= 1'b1;
              sreg_q <= frame_w;
            end else begin
              st_q   <= PH_CMD;
              cnt_q  <= cmd_len_w;
              mdo_q  <= frame_w[SREG_W-1];
              sreg_q <= frame_w << 1;
            end
          end
        end
        PH_PRE: begin
          if (fall_ev) begin
            if (cnt_q == '0) begin
              st_q   <= PH_CMD;
              cnt_q  <= is_rd_q ? CNT_W'(RD_CMD_BITS - 1) : CNT_W'(WR_FRAME_BITS - 1);
              mdo_q  <= sreg_q[SREG_W-1];
              sreg_q <= sreg_q << 1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        PH_CMD: begin
          if (fall_ev) begin
            if (cnt_q == '0) begin
              oe_q  <= 1'b0;
              mdo_q <= 1'b0;
              st_q  <= is_rd_q ? PH_RWIN : PH_TAIL;
              cnt_q <= is_rd_q ? CNT_W'(RD_WIN_BITS - 1) : CNT_W'(TAIL_BITS - 1);
            end else begin
              cnt_q  <= cnt_q - 1'b1;
              mdo_q  <= sreg_q[SREG_W-1];
              sreg_q <= sreg_q << 1;
            end
          end
        end
        PH_RWIN, PH_TAIL: begin
          if (fall_ev) begin
            if (cnt_q == '0) begin
              st_q   <= PH_IDLE;
              run_q  <= 1'b0;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              if (is_rd_q) begin
                err_q <= acc_q[KEEP_W-1];
                rd_q  <= acc_q[KEEP_W-1] ? {DATA_W{1'b1}} : acc_q[DATA_W-1:0];
              end else begin
                err_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign run     = run_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign mdo     = mdo_q;
  assign mdo_oe  = oe_q;
  assign rd_data = rd_q;
  assign err     = err_q;

endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import phy_mgmt_pkg::*;
#(
  parameter int HALF_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_sel,
  input  logic              pre_en,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_oe,
  input  logic              mdi
);

  logic run_w, rise_w, fall_w;

  phy_mgmt_clkgen #(.HALF_CYC(HALF_CYC)) clkgen_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .mdc     (mdc),
    .rise_ev (rise_w),
    .fall_ev (fall_w)
  );

  phy_mgmt_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_sel   (rd_sel),
    .pre_en   (pre_en),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rise_ev  (rise_w),
    .fall_ev  (fall_w),
    .mdi      (mdi),
    .run      (run_w),
    .busy     (busy),
    .done     (done),
    .mdo      (mdo),
    .mdo_oe   (mdo_oe),
    .rd_data  (rd_data),
    .err      (err)
  );

endmodule

// File: rtl/phy_mgmt_master_chk.sv
module phy_mgmt_master_chk #(
  parameter int HALF_CYC = 50
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mdc,
  input logic        mdo,
  input logic        mdo_oe,
  input logic [15:0] rd_data
);

  localparam int SW = $clog2(HALF_CYC + 1) + 1;

  logic          mdc_d;
  logic [SW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d  <= 1'b0;
      held_q <= '0;
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d)              held_q <= SW'(1);
      else if (held_q < SW'(HALF_CYC)) held_q <= held_q + 1'b1;
    end
  end

  // R1
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc != mdc_d) |-> (held_q >= SW'(HALF_CYC)));

  // R3
  mdo_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> $stable(mdo));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdo_oe));

  // R12
  oe_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
    mdo_oe |-> busy);

  // R6
  err_forces_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rd_data == 16'hFFFF));

endmodule

bind phy_mgmt_master phy_mgmt_master_chk #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .mdc     (mdc),
  .mdo     (mdo),
  .mdo_oe  (mdo_oe),
  .rd_data (rd_data)
);

// File: tb/phy_mgmt_master_tb_top.sv
module phy_mgmt_master_tb_top;

  localparam int HALF = 50;
  localparam int NVEC = 6;
  // layout: [46] read, [45] preamble, [44:40] phy, [39:35] reg, [34:19] wdata, [18:0] PHY window response
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 5'h01, 5'h00, 16'h1234, 19'h0},
    {1'b0, 1'b0, 5'h1F, 5'h1F, 16'hA5C3, 19'h0},
    {1'b1, 1'b1, 5'h03, 5'h02, 16'h0000, {1'b1, 1'b0, 16'hBEEF, 1'b1}},
    {1'b1, 1'b0, 5'h10, 5'h05, 16'h0000, {1'b1, 1'b0, 16'h0000, 1'b1}},
    {1'b1, 1'b0, 5'h00, 5'h01, 16'h0000, {1'b1, 1'b1, 16'h1234, 1'b1}},
    {1'b1, 1'b1, 5'h1A, 5'h11, 16'h0000, {1'b0, 1'b0, 16'h8001, 1'b0}}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, rd_sel = 1'b0, pre_en = 1'b0;
  logic [4:0]  phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        busy, done, err, mdc, mdo, mdo_oe, mdi;

  always #2 clk = ~clk;

  phy_mgmt_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_sel(rd_sel), .pre_en(pre_en),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // line monitor and PHY model, all on the falling system clock
  logic [95:0] cap = '0;
  int cap_n = 0, rise_n = 0, win_n = 0, done_n = 0;
  int hold_bad = 0, hi_bad = 0, hi_len = 0;
  logic prev_mdc = 1'b0, prev_mdo = 1'b0;
  int win_base = 0;
  logic [18:0] phy_vec = '0;
  int widx;

  always_comb begin
    widx = win_n - win_base;
    mdi  = (widx >= 0 && widx < 19) ? phy_vec[18 - widx] : 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      rise_n = rise_n + 1;
      if (mdo_oe) begin
        cap   = {cap[94:0], mdo};
        cap_n = cap_n + 1;
      end else begin
        win_n = win_n + 1;
      end
    end
    if (mdc && prev_mdc && (mdo != prev_mdo)) hold_bad = hold_bad + 1;
    if (mdc) hi_len = hi_len + 1;
    else if (prev_mdc) begin
      if (!rst && hi_len != HALF) hi_bad = hi_bad + 1;
      hi_len = 0;
    end
    if (done) done_n = done_n + 1;
    prev_mdc = mdc;
    prev_mdo = mdo;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_bits(input bit rd, input bit pre, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] wd);
    logic [95:0] v;
    if (rd) v = {81'b0, 5'b10110, p, r};
    else    v = {64'b0, 4'b0101, p, r, 2'b10, wd};
    if (pre) v = rd ? (v | (96'hFFFF_FFFF << 15)) : (v | (96'hFFFF_FFFF << 32));
    return v;
  endfunction

  task automatic run_txn(input bit rd, input bit pre, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, input logic [18:0] resp, input bit poke);
    int c0, r0, d0, cyc, nrise, ndrv;
    logic [95:0] mask, ev;
    logic [15:0] old_rd;
    logic old_err;
    ndrv  = (pre ? 32 : 0) + (rd ? 15 : 32);
    nrise = ndrv + (rd ? 19 : 2);
    mask  = (96'd1 << ndrv) - 96'd1;
    ev    = exp_bits(rd, pre, p, r, wd);
    @(negedge clk);
    c0 = cap_n; r0 = rise_n; d0 = done_n;
    win_base = win_n; phy_vec = resp;
    old_rd = rd_data; old_err = err;
    rd_sel = rd; pre_en = pre; phy_addr = p; reg_addr = r; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 300) begin
        // R10: a foreign request while busy
        start = 1'b1; rd_sel = ~rd; pre_en = ~pre; phy_addr = ~p; wr_data = ~wd;
      end else if (poke && cyc == 301) begin
        start = 1'b0;
      end
    end
    chk(cyc == nrise * 2 * HALF, "R1/R9 cycles to done", cyc, nrise * 2 * HALF);
    chk(busy == 1'b0, "R9 busy low with done", busy, 0);
    chk(rise_n - r0 == nrise, rd ? "R5 mdc periods" : "R8 mdc periods", rise_n - r0, nrise);
    chk(cap_n - c0 == ndrv, "R12 driven bit count", cap_n - c0, ndrv);
    chk(((cap ^ ev) & mask) == '0, rd ? "R2/R4 read command bits" : "R2/R7 write frame bits",
        cap & mask, ev & mask);
    if (rd) begin
      chk(rd_data == (resp[17] ? 16'hFFFF : resp[16:1]), "R6 read data", rd_data,
          resp[17] ? 16'hFFFF : resp[16:1]);
      chk(err == resp[17], "R6 err flag", err, resp[17]);
    end else begin
      chk(err == 1'b0 && rd_data == old_rd, "R6 write leaves result", {err, rd_data}, {1'b0, old_rd});
    end
    if (old_err) begin end
    repeat (6) @(negedge clk);
    chk(done_n - d0 == 1, "R9 done pulse count", done_n - d0, 1);
    chk(!busy && !mdc && !mdo_oe, poke ? "R10 no second transaction" : "R11 idle after",
        {busy, mdc, mdo_oe}, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!mdc && !mdo_oe && !busy && !done, "R11 reset state", {mdc, mdo_oe, busy, done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mdc && !mdo_oe && !busy, "R11 idle after reset", {mdc, mdo_oe, busy}, 0);

    for (int i = 0; i < NVEC; i++)
      run_txn(VEC[i][46], VEC[i][45], VEC[i][44:40], VEC[i][39:35], VEC[i][34:19], VEC[i][18:0], 1'b0);

    // R10: start while busy is ignored
    run_txn(1'b0, 1'b0, 5'h05, 5'h0A, 16'h0F0F, 19'h0, 1'b1);
    run_txn(1'b1, 1'b0, 5'h07, 5'h03, 16'h0000, {1'b1, 1'b0, 16'h5A5A, 1'b1}, 1'b1);

    // R3 and R1 line-level tallies over every transaction so far
    chk(hold_bad == 0, "R3 mdo stable while mdc high", hold_bad, 0);
    chk(hi_bad == 0, "R1 mdc high length", hi_bad, 0);

    // R11: reset in mid-transaction
    @(negedge clk);
    rd_sel = 1'b1; pre_en = 1'b1; phy_addr = 5'h02; reg_addr = 5'h04; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (1234) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mdc && !mdo_oe && !busy && !done, "R11 reset mid-transaction", {mdc, mdo_oe, busy, done}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_txn(1'b1, 1'b0, 5'h11, 5'h12, 16'h0000, {1'b0, 1'b0, 16'hC0DE, 1'b1}, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule